// File: doc/BRIEF.md
# Card Reset Sequencer with Host Reset Filtering

This block drives the local reset of a hot-pluggable add-in card, in an active-low and an active-high form, together with an active-low "signal valid" indication to the host. The card leaves reset only when every power-sequencing condition holds: host supplies good, both board-select inputs low, card supplies good, the power-enable input high and the host reset input high. After power becomes valid the reset is held for a programmable minimum interval before it may release.

A host reset input that stays low only briefly is treated as noise and ignored. A longer low starts a reset cycle. That cycle lasts at least the selected minimum width, and it lasts longer if the host keeps its reset low. If card power fails, the reset asserts in the same cycle with no minimum wait. The glitch window is counted in system-clock cycles. The minimum width is counted in ticks of a prescaler, so a short tick can be used in simulation.

The sequencer is a four-state machine:
- `ST_PWR_WAIT`: power not valid, reset held.
- `ST_STRETCH`: minimum-width timer running.
- `ST_HOST_HOLD`: timer done, waiting for the host to release its reset.
- `ST_RUN`: reset released.

Its transitions are:
- power valid: `ST_PWR_WAIT` to `ST_STRETCH`.
- timer done with host high: `ST_STRETCH` to `ST_RUN`.
- timer done with host low: `ST_STRETCH` to `ST_HOST_HOLD`.
- host released: `ST_HOST_HOLD` to `ST_RUN`.
- filtered host reset: `ST_RUN` to `ST_STRETCH`.
- power lost: any state to `ST_PWR_WAIT`.

Top module: `card_reset_ctrl`

## Requirements
- R1: A host reset low seen on at most GLITCH_CYC consecutive clock edges has no effect on any output. A low seen on GLITCH_CYC+1 consecutive edges is accepted as a reset request.
- R2: The minimum width is T = TICK_DIV * (BASE_TICKS << width_sel) clock cycles. With the default BASE_TICKS of 25 and a 1 ms tick, width_sel values 0, 1, 2 and 3 select 25, 50, 100 and 200 ms.
- R3: When the card is running, the host reset is first seen low at edge c+1 and stays low for D edges, with D > GLITCH_CYC and D <= GLITCH_CYC+T+2: reset asserts right after edge c+1+GLITCH_CYC and releases right after edge c+GLITCH_CYC+T+3.
- R4: When the host reset stays low for D > GLITCH_CYC+T+2 edges, reset releases right after edge c+D+1, the first edge that sees the host input high again.
- R5: Reset stays asserted unless all of these hold: host_pwr_ok is 1, both bits of board_sel_n are 0 (active low), card_pwr_ok is 1 and pwr_enable is 1.
- R6: When the last power condition becomes true at edge c+1, reset releases right after edge c+T+2. If the host reset is still low at that point, release waits for the first edge that sees it high.
- R7: sig_valid_n is low exactly when the card reset is released.
- R8: card_rst is always the inverse of card_rst_n.
- R9: Any power condition going false asserts reset combinationally in the same cycle, with no minimum-width wait.
- R10: While rst_n is low, card_rst_n is 0, card_rst is 1 and sig_valid_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| host_rst_n | input | 1 | Host reset request, active low |
| host_pwr_ok | input | 1 | Host supplies above threshold |
| board_sel_n | input | 2 | Board-select inputs, both low when the card is fully seated |
| card_pwr_ok | input | 1 | Card supplies above threshold |
| pwr_enable | input | 1 | Host power enable, active high |
| width_sel | input | SEL_W | Minimum reset width select |
| card_rst_n | output | 1 | Local card reset, active low |
| card_rst | output | 1 | Local card reset, active high |
| sig_valid_n | output | 1 | Card power valid and reset released, active low |

## Verification
The bench aims host pulses right at the glitch boundary (GLITCH_CYC and GLITCH_CYC+1 low edges). A filter that is off by one would either pass noise or drop the shortest valid pulse.

It checks release timing for all four width selections, and for host pulses just at and far beyond the point where the host input, rather than the timer, decides the release. A timer that restarted on its tick instead of on its start, or an FSM that skipped the host-hold state, would release early or late by a predictable number of cycles.

Each power condition is removed on its own while the card is running. This shows that reset asserts in the same cycle and that it does not release until the full stretch has elapsed after restoration. Power-up with the host reset still low confirms that release waits for the host even after the timer has expired.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    typedef enum logic [1:0] {
        ST_PWR_WAIT  = 2'd0,
        ST_STRETCH   = 2'd1,
        ST_HOST_HOLD = 2'd2,
        ST_RUN       = 2'd3
    } rcs_state_e;

endpackage

// File: rtl/rcs_glitch_filter.sv
module rcs_glitch_filter #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_rst_n,
    output logic rst_req
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            rst_req <= 1'b0;
        end else if (host_rst_n) begin
            low_cnt <= '0;
            rst_req <= 1'b0;
        end else begin
            if (low_cnt != CW'(GLITCH_CYC)) begin
                low_cnt <= low_cnt + 1'b1;
            end
            if (low_cnt == CW'(GLITCH_CYC)) begin
                rst_req <= 1'b1;
            end
        end
    end

    // R1: a request is only raised after a low input was seen
    a_r1_req_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(!host_rst_n));

    // R1: a high input drops the request at the next edge
    a_r1_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst_n |=> !rst_req);

endmodule

// File: rtl/rcs_tick_gen.sv
module rcs_tick_gen #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (clear || pre_cnt == LAST) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign tick = (pre_cnt == LAST) && !clear;

    // R2: the prescaler never runs past its last value
    a_r2_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= LAST);

endmodule

// File: rtl/rcs_width_timer.sv
module rcs_width_timer #(
    parameter int BASE_TICKS = 25,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] width_sel,
    input  logic             tick,
    output logic             done
);
    localparam int MAX_TICKS = BASE_TICKS << ((1 << SEL_W) - 1);
    localparam int CW        = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] tick_cnt;
    logic [CW-1:0] target;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            target   <= CW'(BASE_TICKS);
            done     <= 1'b0;
        end else if (start) begin
            tick_cnt <= '0;
            target   <= CW'(BASE_TICKS) << width_sel;
            done     <= 1'b0;
        end else if (!done && tick) begin
            tick_cnt <= tick_cnt + 1'b1;
            if (tick_cnt == target - 1'b1) begin
                done <= 1'b1;
            end
        end
    end

    // R2: once expired the timer stays expired until restarted
    a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R2: a restart always clears the expiry
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

endmodule

// File: rtl/card_reset_ctrl.sv
module card_reset_ctrl #(
    parameter int GLITCH_CYC = 4,
    parameter int TICK_DIV   = 100000,
    parameter int BASE_TICKS = 25,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_rst_n,
    input  logic             host_pwr_ok,
    input  logic [1:0]       board_sel_n,
    input  logic             card_pwr_ok,
    input  logic             pwr_enable,
    input  logic [SEL_W-1:0] width_sel,
    output logic             card_rst_n,
    output logic             card_rst,
    output logic             sig_valid_n
);
    import rcs_pkg::*;

    rcs_state_e state;
    rcs_state_e state_nx;
    logic       pwr_all;
    logic       host_req;
    logic       timer_start;
    logic       timer_done;
    logic       tick;

    assign pwr_all = host_pwr_ok && (board_sel_n == 2'b00) && card_pwr_ok && pwr_enable;

    rcs_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rst_n (host_rst_n),
        .rst_req    (host_req)
    );

    rcs_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_start),
        .tick  (tick)
    );

    rcs_width_timer #(.BASE_TICKS(BASE_TICKS), .SEL_W(SEL_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (timer_start),
        .width_sel (width_sel),
        .tick      (tick),
        .done      (timer_done)
    );

    always_comb begin
        state_nx    = state;
        timer_start = 1'b0;
        unique case (state)
            ST_PWR_WAIT: begin
                if (pwr_all) begin
                    state_nx    = ST_STRETCH;
                    timer_start = 1'b1;
                end
            end
            ST_STRETCH: begin
                if (timer_done) begin
                    state_nx = host_rst_n ? ST_RUN : ST_HOST_HOLD;
                end
            end
            ST_HOST_HOLD: begin
                if (host_rst_n) begin
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (host_req) begin
                    state_nx    = ST_STRETCH;
                    timer_start = 1'b1;
                end
            end
            default: state_nx = ST_PWR_WAIT;
        endcase
        if (!pwr_all) begin
            state_nx    = ST_PWR_WAIT;
            timer_start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PWR_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        card_rst_n  = (state == ST_RUN) && pwr_all && !host_req;
        card_rst    = !card_rst_n;
        sig_valid_n = !card_rst_n;
    end

    // R5 R6: entry into the running state needs full power and a released host
    a_r5_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(host_rst_n) && $past(pwr_all)));

    // R9: loss of any power condition sends the FSM to power wait
    a_r9_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_all |=> state == ST_PWR_WAIT);

    // R6: no release while the stretch timer is still running
    a_r6_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRETCH && !timer_done) |=> state != ST_RUN);

    // R7: signal valid only ever appears in the running state
    a_r7_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_valid_n |-> state == ST_RUN);

endmodule

// File: tb/card_reset_ctrl_bench.sv
module card_reset_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int G     = 4;
    localparam int TD    = 4;
    localparam int BASE  = 25;

    typedef struct {
        int    at;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_rst_n;
    logic       host_pwr_ok;
    logic [1:0] board_sel_n;
    logic       card_pwr_ok;
    logic       pwr_enable;
    logic [1:0] width_sel;
    logic       card_rst_n;
    logic       card_rst;
    logic       sig_valid_n;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   falls = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    card_reset_ctrl #(.GLITCH_CYC(G), .TICK_DIV(TD), .BASE_TICKS(BASE), .SEL_W(2)) u_card_reset_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_rst_n  (host_rst_n),
        .host_pwr_ok (host_pwr_ok),
        .board_sel_n (board_sel_n),
        .card_pwr_ok (card_pwr_ok),
        .pwr_enable  (pwr_enable),
        .width_sel   (width_sel),
        .card_rst_n  (card_rst_n),
        .card_rst    (card_rst),
        .sig_valid_n (sig_valid_n)
    );

    function automatic int tmin();
        return TD * (BASE << width_sel);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int at, input string req);
        exp_t e;
        e.at  = at;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic drain(input string req);
        int g = 0;
        while (q.size() != 0 && g < 4000) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
        chk(q.size() == 0, req, q.size(), 0);
    endtask

    task automatic set_cond(input int idx, input bit good);
        case (idx)
            0: host_pwr_ok    = good;
            1: board_sel_n[0] = !good;
            2: board_sel_n[1] = !good;
            default: pwr_enable = good;
        endcase
    endtask

    task automatic host_pulse(input int d, input string req);
        int c;
        @(negedge clk);
        c = cyc;
        host_rst_n = 1'b0;
        if (d > G) begin
            push(c + (((G + tmin() + 3) > (d + 1)) ? (G + tmin() + 3) : (d + 1)), req);
        end
        repeat (d) @(negedge clk);
        host_rst_n = 1'b1;
    endtask

    // monitor: pops expected release cycles and checks output relations
    initial begin
        logic prev;
        exp_t e;
        prev = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                chk(card_rst == !card_rst_n, "R8", int'(card_rst), int'(!card_rst_n));
                chk(sig_valid_n == !card_rst_n, "R7", int'(sig_valid_n), int'(!card_rst_n));
                if (card_rst_n && !prev) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R5 unexpected release", cyc, -1);
                    end else begin
                        e = q.pop_front();
                        chk(cyc == e.at, e.req, cyc, e.at);
                    end
                end
                if (!card_rst_n && prev) falls++;
            end
            prev = card_rst_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int c;
        int f0;
        rst_n       = 1'b0;
        host_rst_n  = 1'b1;
        host_pwr_ok = 1'b0;
        board_sel_n = 2'b11;
        card_pwr_ok = 1'b0;
        pwr_enable  = 1'b0;
        width_sel   = 2'd0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(card_rst_n == 1'b0, "R10 card_rst_n", int'(card_rst_n), 0);
        chk(card_rst == 1'b1, "R10 card_rst", int'(card_rst), 1);
        chk(sig_valid_n == 1'b1, "R10 sig_valid_n", int'(sig_valid_n), 1);
        rst_n = 1'b1;

        // R5: card power missing keeps reset asserted
        host_pwr_ok = 1'b1;
        board_sel_n = 2'b00;
        pwr_enable  = 1'b1;
        repeat (tmin() + 20) @(negedge clk);
        chk(card_rst_n == 1'b0, "R5 no card power", int'(card_rst_n), 0);

        // R6: power-up stretch
        @(negedge clk);
        c = cyc;
        card_pwr_ok = 1'b1;
        push(c + tmin() + 2, "R6 power-up release");
        drain("R6 drain");

        // R5 R9: each other condition removed alone
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            set_cond(i, 1'b0);
            #1;
            chk(card_rst_n == 1'b0, "R9 immediate assert", int'(card_rst_n), 0);
            repeat (tmin() + 20) @(negedge clk);
            chk(card_rst_n == 1'b0, "R5 held while condition false", int'(card_rst_n), 0);
            @(negedge clk);
            c = cyc;
            set_cond(i, 1'b1);
            push(c + tmin() + 2, "R5 release after restore");
            drain("R5 drain");
        end

        // R1: glitches ignored
        f0 = falls;
        host_pulse(1, "R1");
        repeat (5) @(negedge clk);
        host_pulse(G, "R1");
        repeat (20) @(negedge clk);
        chk(falls == f0, "R1 glitch caused reset", falls, f0);
        chk(card_rst_n == 1'b1, "R1 output still released", int'(card_rst_n), 1);

        // R2 R3: shortest valid pulse for each width
        for (int s = 0; s < 4; s++) begin
            width_sel = 2'(s);
            host_pulse(G + 1, "R3 R2 short pulse release");
            drain("R2 drain");
        end

        // R4: long pulse and boundary
        width_sel = 2'd1;
        host_pulse(G + tmin() + 40, "R4 long pulse release");
        drain("R4 drain");
        host_pulse(G + tmin() + 2, "R4 boundary pulse release");
        drain("R4 boundary drain");

        // R9 R6: card power lost while running, restored with host held low
        width_sel = 2'd0;
        @(negedge clk);
        card_pwr_ok = 1'b0;
        host_rst_n  = 1'b0;
        #1;
        chk(card_rst_n == 1'b0, "R9 card power loss", int'(card_rst_n), 0);
        repeat (5) @(negedge clk);
        card_pwr_ok = 1'b1;
        repeat (tmin() + 30) @(negedge clk);
        chk(card_rst_n == 1'b0, "R6 waits for host", int'(card_rst_n), 0);
        @(negedge clk);
        c = cyc;
        host_rst_n = 1'b1;
        push(c + 1, "R6 release on host high");
        drain("R6 host drain");

        repeat (10) @(negedge clk);
        chk(q.size() == 0, "R3 leftover expectations", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule